// File: doc/BRIEF.md
# Floating-Point Escape Opcode Dispatcher

This block sits between an integer instruction decoder and a stack-organised floating-point arithmetic unit. Each cycle in which the instruction strobe is high, it examines the escape opcode byte (D8 through DF) and the reg and r/m fields of the addressing byte. It then does one of three things: issues a command to the arithmetic unit, runs a control-only instruction itself, or flags the opcode as undefined. It owns the control word, the status word (including the 3-bit stack pointer) and a two-bit-per-slot tag word that records which of the eight stack slots hold data.

Before a command is issued, the dispatcher reads the tags of the destination slot and of the register-form source slot. A divide is also screened against a divisor-is-zero indication from operand fetch. Only commands that pass both screens reach the arithmetic unit. A load path tells the block when a value is pushed, so that the stack pointer and tags stay current. The arithmetic and the memory traffic themselves are done elsewhere.

Top module: `fpu_dispatch`

## Requirements
- R1: After reset, the control word is 16'h037F, the status word is 0, the tag word is 16'hFFFF (all slots empty), and no command or exception output is active.
- R2: For opcodes D8 and DC, the reg field selects the command on op_code with a one-cycle registered delay. The mapping is 0→0 (add), 1→1 (multiply), 2→2 (compare), 3→2 (compare), 4→3 (subtract), 5→3 (subtract), 6→4 (divide) and 7→4 (divide). op_swap is high for reg 5 and 7, op_src_mem copies the memory flag, and op_src_idx is the physical slot (TOP + r/m) mod 8.
- R3: When the top slot's tag is 2'b11 (empty), the invalid-operation flag (status bit 0) is set and no command is issued.
- R4: In register form, an empty source slot (TOP + r/m) sets status bit 0 and blocks the command. In memory form the source tag is not consulted.
- R5: Reg 3 issues a compare with op_pop high. In the same update, the tag of the old top slot becomes 2'b11 and TOP (status bits 13:11) increments mod 8.
- R6: A divide (reg 6 or 7) with divisor_zero high sets the zero-divide flag (status bit 2) and issues nothing. For every other reg value, divisor_zero has no effect.
- R7: DB in register form with index {reg,r/m} = 6'h22 clears status bits 7:0 and bit 15, and keeps the condition bits and TOP.
- R8: DB register index 6'h23 restores the control word to 16'h037F, clears the status word and sets the tag word to 16'hFFFF.
- R9: DB register indices 6'h20 and 6'h21 change no state and raise no exception.
- R10: Every other DB register index, DB in memory form, and opcodes D9, DA, DD, DE and DF pulse ud_exc for one cycle, issue nothing and change no state.
- R11: A push (push_valid high while instr_valid is low) decrements TOP mod 8 and marks the new top slot 2'b00. A push that coincides with instr_valid is ignored.
- R12: An instruction whose opcode is outside D8 to DF has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction strobe |
| opcode | input | 8 | Escape opcode byte |
| reg_field | input | 3 | Reg field of the addressing byte |
| rm_field | input | 3 | R/m field of the addressing byte |
| mem_operand | input | 1 | Source operand comes from memory |
| divisor_zero | input | 1 | Divisor of this instruction is zero |
| push_valid | input | 1 | Load path pushes a value onto the stack |
| op_valid | output | 1 | Command issued to the arithmetic unit |
| op_code | output | 3 | Command: 0 add, 1 multiply, 2 compare, 3 subtract, 4 divide |
| op_swap | output | 1 | Operands reversed |
| op_pop | output | 1 | Stack popped after the command |
| op_src_mem | output | 1 | Source is the memory operand |
| op_src_idx | output | 3 | Physical slot of the register source |
| ud_exc | output | 1 | Undefined-opcode exception pulse |
| control_word | output | 16 | Control word |
| status_word | output | 16 | Status word, TOP in bits 13:11 |
| tag_word | output | 16 | Two tag bits per physical slot |

## Verification
Every reg value under both arithmetic opcodes is sent with three slots filled by pushes. This separates the command encoding, the swap bit and the physical source index from one another. The same instruction is sent once with the source slot empty and once in memory form, which shows that the source tag matters only in register form. The divisor-zero input is raised on a divide and on an add, which tells the zero-divide screen apart from an unconditional block. The control-only and undefined codes are sent after the status word holds flags and a nonzero TOP, so that the clear can be shown to spare the stack pointer.

// File: rtl/fpu_disp_pkg.sv
package fpu_disp_pkg;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_ARITH = 3'd1,
    K_CLEAR = 3'd2,
    K_INIT  = 3'd3,
    K_NOP   = 3'd4,
    K_UNDEF = 3'd5
  } kind_e;

  localparam logic [2:0] CMD_ADD = 3'd0;
  localparam logic [2:0] CMD_MUL = 3'd1;
  localparam logic [2:0] CMD_CMP = 3'd2;
  localparam logic [2:0] CMD_SUB = 3'd3;
  localparam logic [2:0] CMD_DIV = 3'd4;

  localparam int          SW_INVALID = 0;
  localparam int          SW_ZDIV    = 2;
  localparam logic [15:0] SW_CLR_MSK = 16'h80FF;
  localparam logic [1:0]  TAG_EMPTY  = 2'b11;
  localparam logic [1:0]  TAG_LIVE   = 2'b00;

  typedef struct packed {
    kind_e      kind;
    logic [2:0] cmd;
    logic       swap;
    logic       pop;
    logic       is_div;
  } dec_t;

endpackage

// File: rtl/fpu_decode.sv
module fpu_decode
  import fpu_disp_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic [2:0] reg_field,
  input  logic [2:0] rm_field,
  input  logic       mem_operand,
  output dec_t       dec
);

  always_comb begin
    dec      = '0;
    dec.kind = K_NONE;
    if (opcode[7:3] == 5'b11011) begin
      unique case (opcode[2:0])
        3'b000, 3'b100: begin
          dec.kind = K_ARITH;
          unique case (reg_field)
            3'd0: dec.cmd = CMD_ADD;
            3'd1: dec.cmd = CMD_MUL;
            3'd2: dec.cmd = CMD_CMP;
            3'd3: begin dec.cmd = CMD_CMP; dec.pop = 1'b1; end
            3'd4: dec.cmd = CMD_SUB;
            3'd5: begin dec.cmd = CMD_SUB; dec.swap = 1'b1; end
            3'd6: begin dec.cmd = CMD_DIV; dec.is_div = 1'b1; end
            default: begin dec.cmd = CMD_DIV; dec.is_div = 1'b1; dec.swap = 1'b1; end
          endcase
        end
        3'b011: begin
          if (mem_operand) dec.kind = K_UNDEF;
          else begin
            unique case ({reg_field, rm_field})
              6'h22:        dec.kind = K_CLEAR;
              6'h23:        dec.kind = K_INIT;
              6'h20, 6'h21: dec.kind = K_NOP;
              default:      dec.kind = K_UNDEF;
            endcase
          end
        end
        default: dec.kind = K_UNDEF;
      endcase
    end
  end

endmodule

// File: rtl/fpu_tag_file.sv
module fpu_tag_file
  import fpu_disp_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int IDX_W = $clog2(SLOTS)
)(
  input  logic               clk,
  input  logic               rst,
  input  logic [IDX_W-1:0]   top_idx,
  input  logic [IDX_W-1:0]   src_idx,
  input  logic               do_init,
  input  logic               do_pop,
  input  logic               do_push,
  output logic [2*SLOTS-1:0] tag_word,
  output logic               top_empty,
  output logic               src_empty
);

  logic [1:0]       tags [SLOTS];
  logic [IDX_W-1:0] push_slot;

  assign push_slot = top_idx - 1'b1;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || do_init)
        tags[i] <= TAG_EMPTY;
      else if (do_pop && top_idx == IDX_W'(i))
        tags[i] <= TAG_EMPTY;
      else if (do_push && push_slot == IDX_W'(i))
        tags[i] <= TAG_LIVE;
    end
    assign tag_word[2*i +: 2] = tags[i];
  end

  assign top_empty = (tags[top_idx] == TAG_EMPTY);
  assign src_empty = (tags[src_idx] == TAG_EMPTY);

endmodule

// File: rtl/fpu_dispatch.sv
module fpu_dispatch
  import fpu_disp_pkg::*;
#(
  parameter int          SLOTS     = 8,
  parameter logic [15:0] CTRL_INIT = 16'h037F
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        instr_valid,
  input  logic [7:0]  opcode,
  input  logic [2:0]  reg_field,
  input  logic [2:0]  rm_field,
  input  logic        mem_operand,
  input  logic        divisor_zero,
  input  logic        push_valid,
  output logic        op_valid,
  output logic [2:0]  op_code,
  output logic        op_swap,
  output logic        op_pop,
  output logic        op_src_mem,
  output logic [2:0]  op_src_idx,
  output logic        ud_exc,
  output logic [15:0] control_word,
  output logic [15:0] status_word,
  output logic [15:0] tag_word
);

  localparam int TOP_LO = 11;
  localparam int TOP_HI = TOP_LO + 2;

  dec_t       dec;
  logic [2:0] top, src_phys;
  logic       top_empty, src_empty;
  logic       is_arith, blocked, zdiv_hit, issue;
  logic       do_pop, do_init, do_push;

  fpu_decode u_decode (
    .opcode      (opcode),
    .reg_field   (reg_field),
    .rm_field    (rm_field),
    .mem_operand (mem_operand),
    .dec         (dec)
  );

  always_comb begin
    top      = status_word[TOP_HI:TOP_LO];
    src_phys = top + rm_field;
    is_arith = instr_valid && (dec.kind == K_ARITH);
    blocked  = top_empty || (!mem_operand && src_empty);
    zdiv_hit = dec.is_div && divisor_zero;
    issue    = is_arith && !blocked && !zdiv_hit;
    do_pop   = issue && dec.pop;
    do_init  = instr_valid && (dec.kind == K_INIT);
    do_push  = push_valid && !instr_valid;
  end

  fpu_tag_file #(.SLOTS(SLOTS)) u_tags (
    .clk       (clk),
    .rst       (rst),
    .top_idx   (top),
    .src_idx   (src_phys),
    .do_init   (do_init),
    .do_pop    (do_pop),
    .do_push   (do_push),
    .tag_word  (tag_word),
    .top_empty (top_empty),
    .src_empty (src_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      control_word <= CTRL_INIT;
      status_word  <= '0;
      op_valid     <= 1'b0;
      op_code      <= '0;
      op_swap      <= 1'b0;
      op_pop       <= 1'b0;
      op_src_mem   <= 1'b0;
      op_src_idx   <= '0;
      ud_exc       <= 1'b0;
    end else begin
      op_valid   <= 1'b0;
      op_code    <= '0;
      op_swap    <= 1'b0;
      op_pop     <= 1'b0;
      op_src_mem <= 1'b0;
      op_src_idx <= '0;
      ud_exc     <= 1'b0;
      if (instr_valid) begin
        unique case (dec.kind)
          K_ARITH: begin
            if (blocked)
              status_word[SW_INVALID] <= 1'b1;
            else if (zdiv_hit)
              status_word[SW_ZDIV] <= 1'b1;
            else begin
              op_valid   <= 1'b1;
              op_code    <= dec.cmd;
              op_swap    <= dec.swap;
              op_pop     <= dec.pop;
              op_src_mem <= mem_operand;
              op_src_idx <= src_phys;
              if (dec.pop) status_word[TOP_HI:TOP_LO] <= top + 3'd1;
            end
          end
          K_CLEAR: status_word <= status_word & ~SW_CLR_MSK;
          K_INIT: begin
            control_word <= CTRL_INIT;
            status_word  <= '0;
          end
          K_UNDEF: ud_exc <= 1'b1;
          default: ;
        endcase
      end else if (do_push) begin
        status_word[TOP_HI:TOP_LO] <= top - 3'd1;
      end
    end
  end

endmodule

// File: rtl/fpu_dispatch_chk.sv
module fpu_dispatch_chk (
  input logic        clk,
  input logic        rst,
  input logic        divisor_zero,
  input logic        op_valid,
  input logic [2:0]  op_code,
  input logic        op_pop,
  input logic        ud_exc,
  input logic [15:0] status_word,
  input logic [15:0] tag_word
);

  logic [1:0] top_tag;
  always_comb top_tag = tag_word[2*status_word[13:11] +: 2];

  // R5: a pop advances the stack pointer by one
  a_r5_pop_moves_top: assert property (@(posedge clk) disable iff (rst)
    op_pop |-> status_word[13:11] == $past(status_word[13:11]) + 3'd1);

  // R5: only a compare carries a pop
  a_r5_pop_is_compare: assert property (@(posedge clk) disable iff (rst)
    op_pop |-> (op_valid && op_code == 3'd2));

  // R3: an issued command had a live top slot
  a_r3_top_was_live: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> $past(top_tag) != 2'b11);

  // R6: no divide is issued against a zero divisor
  a_r6_no_zero_divide: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 3'd4) |-> !$past(divisor_zero));

  // R10: an undefined opcode issues nothing and leaves the tags alone
  a_r10_ud_quiet: assert property (@(posedge clk) disable iff (rst)
    ud_exc |-> (!op_valid && $stable(tag_word)));

endmodule

bind fpu_dispatch fpu_dispatch_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .divisor_zero (divisor_zero),
  .op_valid     (op_valid),
  .op_code      (op_code),
  .op_pop       (op_pop),
  .ud_exc       (ud_exc),
  .status_word  (status_word),
  .tag_word     (tag_word)
);

// File: tb/fpu_dispatch_bench.sv
module fpu_dispatch_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [7:0]  opcode = '0;
  logic [2:0]  reg_field = '0;
  logic [2:0]  rm_field = '0;
  logic        mem_operand = 1'b0;
  logic        divisor_zero = 1'b0;
  logic        push_valid = 1'b0;
  logic        op_valid, op_swap, op_pop, op_src_mem, ud_exc;
  logic [2:0]  op_code, op_src_idx;
  logic [15:0] control_word, status_word, tag_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpu_dispatch u_fpu_dispatch (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .opcode(opcode),
    .reg_field(reg_field), .rm_field(rm_field), .mem_operand(mem_operand),
    .divisor_zero(divisor_zero), .push_valid(push_valid),
    .op_valid(op_valid), .op_code(op_code), .op_swap(op_swap), .op_pop(op_pop),
    .op_src_mem(op_src_mem), .op_src_idx(op_src_idx), .ud_exc(ud_exc),
    .control_word(control_word), .status_word(status_word), .tag_word(tag_word)
  );

  logic [58:0] exp_q[$];
  string       req_q[$];
  int          checks = 0;
  int          fails  = 0;
  bit          finished = 1'b0;

  logic [15:0] m_ctrl = 16'h037F;
  logic [15:0] m_stw  = 16'h0000;
  logic [15:0] m_tag  = 16'hFFFF;

  function automatic logic [2:0] cmd_of(input logic [2:0] rg);
    case (rg)
      3'd0: return 3'd0;
      3'd1: return 3'd1;
      3'd2, 3'd3: return 3'd2;
      3'd4, 3'd5: return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  task automatic step(input logic v, input logic [7:0] opc, input logic [2:0] rg,
                      input logic [2:0] rm, input logic mem, input logic dz,
                      input logic ps, input string req);
    logic ov, sw, pp, sm, ud;
    logic [2:0] oc, si, t, s;
    @(negedge clk);
    instr_valid = v; opcode = opc; reg_field = rg; rm_field = rm;
    mem_operand = mem; divisor_zero = dz; push_valid = ps;
    ov = 0; sw = 0; pp = 0; sm = 0; ud = 0; oc = 0; si = 0;
    t = m_stw[13:11];
    s = t + rm;
    if (v) begin
      if (opc == 8'hD8 || opc == 8'hDC) begin
        if (m_tag[2*t +: 2] == 2'b11 || (!mem && m_tag[2*s +: 2] == 2'b11))
          m_stw[0] = 1'b1;
        else if (rg >= 3'd6 && dz)
          m_stw[2] = 1'b1;
        else begin
          ov = 1; oc = cmd_of(rg); sw = (rg == 3'd5 || rg == 3'd7);
          pp = (rg == 3'd3); sm = mem; si = s;
          if (pp) begin m_tag[2*t +: 2] = 2'b11; m_stw[13:11] = t + 3'd1; end
        end
      end else if (opc == 8'hDB) begin
        if (mem) ud = 1;
        else case ({rg, rm})
          6'h22: m_stw = m_stw & ~16'h80FF;
          6'h23: begin m_ctrl = 16'h037F; m_stw = 16'h0; m_tag = 16'hFFFF; end
          6'h20, 6'h21: ;
          default: ud = 1;
        endcase
      end else if (opc[7:3] == 5'b11011) ud = 1;
    end else if (ps) begin
      t = t - 3'd1;
      m_stw[13:11] = t;
      m_tag[2*t +: 2] = 2'b00;
    end
    exp_q.push_back({ov, oc, sw, pp, sm, si, ud, m_ctrl, m_stw, m_tag});
    req_q.push_back(req);
  endtask

  task automatic idle(input string req);
    step(0, 8'h00, 0, 0, 0, 0, 0, req);
  endtask

  // monitor: compares each cycle's outputs against the queued expectation
  initial begin
    logic [58:0] e, o;
    string r;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        r = req_q.pop_front();
        o = {op_valid, op_code, op_swap, op_pop, op_src_mem, op_src_idx, ud_exc,
             control_word, status_word, tag_word};
        checks++;
        if (o !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", r, o, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle("R1 reset state");
    step(1, 8'hD8, 0, 0, 0, 0, 0, "R3 empty top");
    step(1, 8'hDB, 4, 2, 0, 0, 0, "R7 clear");
    step(0, 8'h00, 0, 0, 0, 0, 1, "R11 push 1");
    step(0, 8'h00, 0, 0, 0, 0, 1, "R11 push 2");
    step(0, 8'h00, 0, 0, 0, 0, 1, "R11 push 3");
    step(1, 8'hD8, 0, 0, 0, 0, 0, "R2 add");
    step(1, 8'hD8, 1, 1, 0, 0, 0, "R2 multiply");
    step(1, 8'hDC, 2, 2, 0, 0, 0, "R2 compare");
    step(1, 8'hDC, 4, 2, 0, 0, 0, "R2 subtract");
    step(1, 8'hD8, 5, 1, 0, 0, 0, "R2 reverse subtract");
    step(1, 8'hDC, 6, 0, 0, 0, 0, "R2 divide");
    step(1, 8'hD8, 7, 1, 0, 0, 0, "R2 reverse divide");
    step(1, 8'hD8, 0, 3, 0, 0, 0, "R4 empty source");
    step(1, 8'hD8, 0, 3, 1, 0, 0, "R4 memory source");
    step(1, 8'hD8, 6, 1, 0, 1, 0, "R6 zero divide");
    step(1, 8'hDC, 7, 1, 1, 1, 0, "R6 zero reverse divide");
    step(1, 8'hD8, 0, 1, 0, 1, 0, "R6 add ignores divisor flag");
    step(1, 8'hD8, 3, 1, 0, 0, 0, "R5 compare pop");
    step(1, 8'hD8, 0, 0, 0, 0, 0, "R5 popped slot empty");
    step(1, 8'h90, 0, 0, 0, 0, 1, "R12 non-escape with push R11");
    step(1, 8'hDB, 4, 0, 0, 0, 0, "R9 nop 20");
    step(1, 8'hDB, 4, 1, 0, 0, 0, "R9 nop 21");
    step(1, 8'hDB, 4, 4, 0, 0, 0, "R10 undefined index");
    step(1, 8'hDB, 4, 2, 1, 0, 0, "R10 memory form");
    step(1, 8'hD9, 0, 0, 0, 0, 0, "R10 D9");
    step(1, 8'hDF, 3, 5, 0, 0, 0, "R10 DF");
    step(1, 8'hDB, 4, 2, 0, 0, 0, "R7 clear keeps TOP");
    step(1, 8'hD8, 0, 0, 0, 1, 0, "R6 status after clear");
    step(1, 8'hDB, 4, 3, 0, 0, 0, "R8 init");
    step(1, 8'hDC, 1, 0, 1, 0, 0, "R8 stack empty after init");
    idle("R1 idle");
    idle("R1 idle");
    while (exp_q.size() > 0) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule